// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register memory transfer request into a stream of single-word beats. A request gives a base address, a 16-bit mask of the registers to move, one of four addressing modes, a load/store direction and a base-update flag. The sequencer then offers one beat per cycle through a valid/ready handshake. Each beat carries a register index, a word address and the direction.

Registers always go out in ascending index order at ascending addresses, so the lowest-numbered register in the mask sits at the lowest address whatever the mode. The mode decides only where the block of words starts relative to the base: at the base or one word above it when counting up, and ending at the base or one word below it when counting down. When the whole list has been accepted, the block pulses a completion flag. If the base-update flag was set, it also pulses a write-enable together with the new base, which is the old base moved by four bytes per register in the direction of the mode.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset the block is idle: busy_o, xfer_valid_o, done_o and wb_en_o are all low.
- R2: Mode 0 (count up, address used before the step): the first beat's address equals the base.
- R3: Mode 1 (count up, step before use): the first beat's address equals base + 4.
- R4: Mode 2 (count down, address used before the step): the first beat's address equals base − 4n + 4, where n is the number of set bits in the list.
- R5: Mode 3 (count down, step before use): the first beat's address equals base − 4n.
- R6: Beats carry the set register indices in strictly ascending order, and each accepted beat raises the next beat's address by exactly 4.
- R7: While xfer_valid_o is high and xfer_ready_i is low, the beat is held: valid stays high and the address and register index do not change.
- R8: xfer_load_o on every beat equals the direction bit captured with the start strobe.
- R9: done_o is high for exactly one cycle, in the cycle right after the last beat is accepted. busy_o is low in the cycle after that.
- R10: When the base-update flag is set and the list is not empty, wb_en_o pulses together with done_o and wb_base_o equals base + 4n for modes 0 and 1, or base − 4n for modes 2 and 3. wb_en_o stays low when the flag is clear.
- R11: An empty register list produces no beats and no base update. done_o pulses in the cycle after the start strobe.
- R12: A start strobe that arrives while busy_o is high is ignored, and the ongoing transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| base_i | input | 32 | Base byte address |
| reglist_i | input | 16 | Register mask, bit k selects register k |
| mode_i | input | 2 | Addressing mode: 0 up-after, 1 up-before, 2 down-after, 3 down-before |
| load_i | input | 1 | Direction: 1 load, 0 store |
| wb_i | input | 1 | Request base update at the end |
| busy_o | output | 1 | A transfer is in progress |
| xfer_valid_o | output | 1 | Beat offered |
| xfer_ready_i | input | 1 | Memory accepts the beat |
| xfer_reg_o | output | 4 | Register index of the beat |
| xfer_addr_o | output | 32 | Word address of the beat |
| xfer_load_o | output | 1 | Direction of the beat |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | One-cycle base update enable |
| wb_base_o | output | 32 | Updated base value |

## Verification
The assertions assume that xfer_ready_i is a plain acceptance signal with no constraint on when it may rise or fall. They also assume that the request fields are only meaningful in the cycle when start_i is sampled while the block is idle. The stimulus changes every input only at the falling edge. It drives the request fields together with the strobe and varies readiness with fixed bit patterns, which include long stall runs. Any strobe raised during a transfer carries different fields on purpose, so that a wrongly accepted request shows up at the ports.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        AM_UP_AFTER   = 2'd0,
        AM_UP_BEFORE  = 2'd1,
        AM_DN_AFTER   = 2'd2,
        AM_DN_BEFORE  = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/blkxfer_pick.sv
// Finds the lowest set bit of a mask and the mask with that bit removed.
module blkxfer_pick #(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  mask_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o,
    output logic [NREG-1:0]  rest_o,
    output logic             last_o
);

    logic [NREG-1:0] lowest;

    // one-hot of the lowest set bit, built per position
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_low
            if (g == 0) begin : g_first
                assign lowest[g] = mask_i[g];
            end else begin : g_rest
                assign lowest[g] = mask_i[g] && (mask_i[g-1:0] == '0);
            end
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NREG; k++) begin
            if (lowest[k]) idx_o = IDX_W'(k);
        end
    end

    assign any_o  = |mask_i;
    assign rest_o = mask_i & ~lowest;
    assign last_o = any_o && (rest_o == '0);

endmodule

// File: rtl/blkxfer_plan.sv
// Computes start address and final base from base, list and mode.
module blkxfer_plan
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int CNT_W     = $clog2(NREG + 1)
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   list_i,
    input  logic [1:0]        mode_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] final_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    addr_mode_e       mode;
    logic [ADDR_W-1:0] span;

    always_comb begin
        count_o = '0;
        for (int k = 0; k < NREG; k++) begin
            count_o = count_o + CNT_W'(list_i[k]);
        end
    end

    assign mode = addr_mode_e'(mode_i);
    assign span = ADDR_W'(count_o) * STEP;

    always_comb begin
        unique case (mode)
            AM_UP_AFTER:  first_o = base_i;
            AM_UP_BEFORE: first_o = base_i + STEP;
            AM_DN_AFTER:  first_o = base_i - span + STEP;
            default:      first_o = base_i - span;
        endcase
        final_o = mode_i[1] ? (base_i - span) : (base_i + span);
    end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG),
    localparam int CNT_W     = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   reglist_i,
    input  logic [1:0]        mode_i,
    input  logic              load_i,
    input  logic              wb_i,
    output logic              busy_o,
    output logic              xfer_valid_o,
    input  logic              xfer_ready_i,
    output logic [IDX_W-1:0]  xfer_reg_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic              xfer_load_o,
    output logic              done_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_base_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        seq_state_e        st;
        logic [NREG-1:0]   mask;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] fin;
        logic              load;
        logic              wb;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [CNT_W-1:0]  plan_cnt;
    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_final;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic [NREG-1:0]   pick_rest;
    logic              pick_last;

    blkxfer_plan #(
        .ADDR_W     (ADDR_W),
        .NREG       (NREG),
        .WORD_BYTES (WORD_BYTES)
    ) u_plan (
        .base_i  (base_i),
        .list_i  (reglist_i),
        .mode_i  (mode_i),
        .count_o (plan_cnt),
        .first_o (plan_first),
        .final_o (plan_final)
    );

    blkxfer_pick #(
        .NREG (NREG)
    ) u_pick (
        .mask_i (ctx_q.mask),
        .idx_o  (pick_idx),
        .any_o  (pick_any),
        .rest_o (pick_rest),
        .last_o (pick_last)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    ctx_d.mask = reglist_i;
                    ctx_d.addr = plan_first;
                    ctx_d.fin  = plan_final;
                    ctx_d.load = load_i;
                    ctx_d.wb   = wb_i && (plan_cnt != '0);
                    ctx_d.st   = (plan_cnt == '0) ? SEQ_FIN : SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (xfer_ready_i) begin
                    ctx_d.mask = pick_rest;
                    ctx_d.addr = ctx_q.addr + STEP;
                    if (pick_last) ctx_d.st = SEQ_FIN;
                end
            end
            default: begin
                ctx_d.st = SEQ_IDLE;
                ctx_d.wb = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '{st: SEQ_IDLE, default: '0};
        else        ctx_q <= ctx_d;
    end

    assign busy_o       = (ctx_q.st != SEQ_IDLE);
    assign xfer_valid_o = (ctx_q.st == SEQ_RUN) && pick_any;
    assign xfer_reg_o   = pick_idx;
    assign xfer_addr_o  = ctx_q.addr;
    assign xfer_load_o  = ctx_q.load;
    assign done_o       = (ctx_q.st == SEQ_FIN);
    assign wb_en_o      = done_o && ctx_q.wb;
    assign wb_base_o    = ctx_q.fin;

    // ---------------- assertions ----------------
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o) |-> (!xfer_valid_o && !done_o && !wb_en_o));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && !xfer_ready_i) |=>
        (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o) && $stable(xfer_load_o)));

    p_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && xfer_ready_i) |=>
        (!xfer_valid_o || ((xfer_reg_o > $past(xfer_reg_o)) && (xfer_addr_o == $past(xfer_addr_o) + STEP))));

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && xfer_ready_i && $countones(ctx_q.mask) == 1) |=> (done_o && !xfer_valid_o));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_wb_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o);

    p_empty_list_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && reglist_i == '0) |=> (done_o && !wb_en_o && !xfer_valid_o));

    p_busy_ignores_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o && !(xfer_valid_o && xfer_ready_i)) |=>
        ($stable(xfer_addr_o) && $stable(wb_base_o)));

endmodule

// File: tb/blkxfer_seq_tb.sv
`timescale 1ns/1ps
module blkxfer_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] reglist_i = '0;
    logic [1:0]  mode_i = '0;
    logic        load_i = 1'b0;
    logic        wb_i = 1'b0;
    logic        busy_o, xfer_valid_o, xfer_load_o, done_o, wb_en_o;
    logic        xfer_ready_i = 1'b0;
    logic [3:0]  xfer_reg_o;
    logic [31:0] xfer_addr_o, wb_base_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    blkxfer_seq u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .base_i (base_i),
        .reglist_i (reglist_i), .mode_i (mode_i), .load_i (load_i), .wb_i (wb_i),
        .busy_o (busy_o), .xfer_valid_o (xfer_valid_o), .xfer_ready_i (xfer_ready_i),
        .xfer_reg_o (xfer_reg_o), .xfer_addr_o (xfer_addr_o), .xfer_load_o (xfer_load_o),
        .done_o (done_o), .wb_en_o (wb_en_o), .wb_base_o (wb_base_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int low_idx(input logic [15:0] m);
        for (int k = 15; k >= 0; k--) if (m[k]) low_idx = k;
    endfunction

    task automatic run_op(input logic [31:0] base, input logic [15:0] list, input logic [1:0] mode,
                          input bit ld, input bit wb, input logic [7:0] rpat, input bit inject);
        int n = $countones(list);
        logic [31:0] span = 32'(n) * 32'd4;
        logic [31:0] first, fin, exp_addr;
        logic [15:0] remaining = list;
        int cyc = 0;
        bit done_seen = 0, last_prev = 0, first_beat = 1;
        string tag;
        case (mode)
            2'd0: begin first = base;               tag = "R2"; end
            2'd1: begin first = base + 32'd4;       tag = "R3"; end
            2'd2: begin first = base - span + 32'd4; tag = "R4"; end
            default: begin first = base - span;     tag = "R5"; end
        endcase
        fin = mode[1] ? base - span : base + span;
        exp_addr = first;
        @(negedge clk);
        start_i = 1; base_i = base; reglist_i = list; mode_i = mode; load_i = ld; wb_i = wb;
        xfer_ready_i = 0;
        @(posedge clk); @(negedge clk);
        start_i = 0;
        while (!done_seen && cyc < 400) begin
            xfer_ready_i = rpat[cyc % 8];
            if (inject && cyc == 1) begin
                start_i = 1; base_i = ~base; reglist_i = ~list; mode_i = mode ^ 2'd2; wb_i = ~wb; load_i = ~ld;
            end else start_i = 0;
            if (done_o) begin
                // R9 done right after last accepted beat; R11 empty list done next cycle
                if (n == 0) chk(cyc == 0, "R11", 32'(cyc), 32'd0);
                else        chk(last_prev, "R9", 32'(last_prev), 32'd1);
                chk(remaining == 0, "R9", 32'(remaining), 32'd0);
                chk(!xfer_valid_o, "R9", 32'(xfer_valid_o), 32'd0);
                chk(wb_en_o == (wb && n != 0), (n == 0) ? "R11" : "R10", 32'(wb_en_o), 32'(wb && n != 0));
                if (wb && n != 0) chk(wb_base_o == fin, "R10", wb_base_o, fin);
                done_seen = 1;
            end else begin
                chk(xfer_valid_o == (remaining != 0), (n == 0) ? "R11" : "R6", 32'(xfer_valid_o), 32'(remaining != 0));
                if (xfer_valid_o && remaining != 0) begin
                    chk(32'(xfer_reg_o) == 32'(low_idx(remaining)), inject ? "R12" : "R6", 32'(xfer_reg_o), 32'(low_idx(remaining)));
                    chk(xfer_addr_o == exp_addr, first_beat ? tag : (xfer_ready_i ? "R6" : "R7"), xfer_addr_o, exp_addr);
                    chk(xfer_load_o == ld, "R8", 32'(xfer_load_o), 32'(ld));
                    first_beat = 0;
                end
                last_prev = xfer_valid_o && xfer_ready_i && ($countones(remaining) == 1);
                if (xfer_valid_o && xfer_ready_i && remaining != 0) begin
                    remaining[low_idx(remaining)] = 1'b0;
                    exp_addr = exp_addr + 32'd4;
                end
            end
            cyc++;
            @(posedge clk); @(negedge clk);
        end
        start_i = 0; xfer_ready_i = 0;
        chk(done_seen, "R9", 32'(done_seen), 32'd1);
        chk(!busy_o && !done_o, inject ? "R12" : "R9", {busy_o, done_o}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lists [8];
        logic [7:0]  pats  [3];
        int op = 0;
        lists = '{16'h0001, 16'h8000, 16'hFFFF, 16'h0000, 16'h1234, 16'h8421, 16'h00F0, 16'h6001};
        pats  = '{8'hFF, 8'b1011_0010, 8'b0100_0001};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !xfer_valid_o && !done_o && !wb_en_o, "R1",
            {busy_o, xfer_valid_o, done_o, wb_en_o}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R1", {busy_o, done_o}, 32'd0);
        for (int li = 0; li < 8; li++)
            for (int m = 0; m < 4; m++)
                for (int w = 0; w < 2; w++)
                    for (int p = 0; p < 3; p++) begin
                        logic [31:0] b = (op % 5 == 0) ? 32'h0000_0008 : 32'h1000_0000 + 32'(op) * 32'h104;
                        run_op(b, lists[li], 2'(m), op[0], w[0], pats[p], (p == 2));
                        op++;
                    end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule